// File: doc/BRIEF.md
# PCI Target Memory Address Decoder

This block decides, at the start of each PCI transaction, whether a host bridge should claim it as a target so that an external bus master can read or write local SDRAM. It looks at the command code and address from the address phase, a memory-response enable bit, the installed SDRAM size, and local copies of two address-region registers. Only memory commands are accepted. The target window begins at address zero and ends at the top of installed SDRAM. No base address register is involved. Any region copy that routes its space to the PCI bus cuts a hole in that window.

The decision is made on the clock where the transaction begins. It is registered, so the device-select response can be driven one clock later (medium decode timing). The claim is a one-clock pulse. In the same cycle the block presents the SDRAM address that the accepted access maps to. That address is the bus address itself. The protocol state machine that holds device-select for the rest of the transaction lives outside this block.

Top module: `pci_tgt_mem_decode`

## Requirements
- R1: While `rst` is high, and in the cycle after it is released, `claim` is 0 and `sdram_addr` is 0.
- R2: Only command codes 4'b0110, 4'b0111, 4'b1100, 4'b1110 and 4'b1111 can be claimed. Every other code, including the I/O and configuration codes, is never claimed.
- R3: When `mem_en` is 0, no transaction is claimed.
- R4: The window covers addresses from 0 up to `sdram_mb` × 2^20 − 1. `sdram_mb` gives the size in 1 MB units, and a value of 0 claims nothing.
- R5: A `sdram_mb` value above 256 is treated as 256, so an address at or above 0x1000_0000 is never claimed.
- R6: Region i is described by four fields: `reg_en[i]`, the target field `reg_tgt[3i+2:3i]`, the base `reg_base[20i+19:20i]` in 4 KB pages, and the size `reg_pages[20i+19:20i]` in 4 KB pages. When the region is enabled and its target is 3'b001 (PCI bus), an address with base×4096 ≤ addr < (base+size)×4096 is not claimed.
- R7: A region that is disabled, or whose target field is not 3'b001, has no effect on the decision.
- R8: `claim` goes high only in the cycle after a cycle with `frame_start` high, and it lasts one cycle per start strobe. When `frame_start` is low, the block claims nothing.
- R9: While `claim` is high, `sdram_addr` equals the address sampled with the start strobe. While `claim` is low, `sdram_addr` is 0.
- R10: A region size of 0 excludes nothing. The region end is computed without wrap-around, so a region that reaches past 4 GB still excludes its whole span below 4 GB.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_start | input | 1 | High on the clock where a transaction's address phase begins |
| cmd | input | 4 | PCI command code of the address phase |
| addr | input | 32 | PCI address of the address phase |
| mem_en | input | 1 | Memory-response enable from the command register |
| sdram_mb | input | 9 | Installed SDRAM size in MB |
| reg_en | input | 2 | Enable bit of each region copy |
| reg_tgt | input | 6 | Target field of each region copy, 3 bits each |
| reg_base | input | 40 | Base of each region in 4 KB pages, 20 bits each |
| reg_pages | input | 40 | Size of each region in 4 KB pages, 20 bits each |
| claim | output | 1 | Registered claim pulse, one clock after the start strobe |
| sdram_addr | output | 32 | Mapped SDRAM address; valid while claim is high, zero otherwise |

## Verification
The bench builds the block with its default parameters: two region copies, a 9-bit size field, and a 256 MB cap. With these values, a size above the cap, the 0x1000_0000 limit and both regions can all be driven directly. Directed steps cover these boundaries and the region edges:
- the last byte inside a window or hole, and the first byte past it;
- a region whose end would pass 4 GB;
- a region of size zero.

A random phase then biases addresses toward those edges and mixes all sixteen command codes. A behavioural model computes the expected claim and address for every clock.

// File: rtl/pci_tgt_pkg.sv
package pci_tgt_pkg;

    localparam int ADDR_W     = 32;
    localparam int PAGE_SHIFT = 12;
    localparam int PAGE_W     = ADDR_W - PAGE_SHIFT;
    localparam int MB_SHIFT   = 20;
    localparam int TGT_W      = 3;
    localparam logic [TGT_W-1:0] TGT_PCI = 3'b001;

    typedef enum logic [3:0] {
        CMD_MEM_RD      = 4'b0110,
        CMD_MEM_WR      = 4'b0111,
        CMD_MEM_RD_MULT = 4'b1100,
        CMD_MEM_RD_LINE = 4'b1110,
        CMD_MEM_WR_INV  = 4'b1111
    } mem_cmd_e;

    typedef struct packed {
        logic              en;
        logic [TGT_W-1:0]  tgt;
        logic [PAGE_W-1:0] base;
        logic [PAGE_W-1:0] pages;
    } region_t;

    function automatic logic [ADDR_W:0] page_to_addr(input logic [PAGE_W-1:0] pg);
        return {1'b0, pg, {PAGE_SHIFT{1'b0}}};
    endfunction

endpackage

// File: rtl/ptd_cmd_filter.sv
module ptd_cmd_filter
    import pci_tgt_pkg::*;
(
    input  logic [3:0] cmd,
    output logic       is_mem
);
    always_comb begin
        case (cmd)
            CMD_MEM_RD, CMD_MEM_WR, CMD_MEM_RD_MULT,
            CMD_MEM_RD_LINE, CMD_MEM_WR_INV: is_mem = 1'b1;
            default:                         is_mem = 1'b0;
        endcase
    end
endmodule

// File: rtl/ptd_sdram_window.sv
module ptd_sdram_window
    import pci_tgt_pkg::*;
#(
    parameter int SIZE_W = 9,
    parameter int MAX_MB = 256
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [SIZE_W-1:0] size_mb,
    output logic              in_window
);
    localparam int TOP_W = ADDR_W + 1;
    localparam logic [SIZE_W-1:0] CAP = SIZE_W'(MAX_MB);

    logic [SIZE_W-1:0] eff_mb;
    logic [TOP_W-1:0]  top_addr;

    always_comb begin
        eff_mb    = (size_mb > CAP) ? CAP : size_mb;
        top_addr  = TOP_W'(eff_mb) << MB_SHIFT;
        in_window = {1'b0, addr} < top_addr;
    end
endmodule

// File: rtl/ptd_region_hit.sv
module ptd_region_hit
    import pci_tgt_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  region_t           region,
    output logic              hole
);
    logic [ADDR_W:0] lo;
    logic [ADDR_W:0] hi;
    logic [ADDR_W:0] a_ext;

    always_comb begin
        lo    = page_to_addr(region.base);
        hi    = lo + page_to_addr(region.pages);
        a_ext = {1'b0, addr};
        hole  = region.en && (region.tgt == TGT_PCI) && (a_ext >= lo) && (a_ext < hi);
    end
endmodule

// File: rtl/pci_tgt_mem_decode.sv
module pci_tgt_mem_decode
    import pci_tgt_pkg::*;
#(
    parameter int NUM_REGIONS = 2,
    parameter int SIZE_W      = 9,
    parameter int MAX_MB      = 256
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          frame_start,
    input  logic [3:0]                    cmd,
    input  logic [ADDR_W-1:0]             addr,
    input  logic                          mem_en,
    input  logic [SIZE_W-1:0]             sdram_mb,
    input  logic [NUM_REGIONS-1:0]        reg_en,
    input  logic [TGT_W*NUM_REGIONS-1:0]  reg_tgt,
    input  logic [PAGE_W*NUM_REGIONS-1:0] reg_base,
    input  logic [PAGE_W*NUM_REGIONS-1:0] reg_pages,
    output logic                          claim,
    output logic [ADDR_W-1:0]             sdram_addr
);
    localparam logic [ADDR_W-1:0] LIMIT = ADDR_W'(MAX_MB) << MB_SHIFT;

    logic                   is_mem;
    logic                   in_window;
    logic [NUM_REGIONS-1:0] holes;
    logic                   decide;

    ptd_cmd_filter u_cmd (
        .cmd    (cmd),
        .is_mem (is_mem)
    );

    ptd_sdram_window #(.SIZE_W(SIZE_W), .MAX_MB(MAX_MB)) u_win (
        .addr      (addr),
        .size_mb   (sdram_mb),
        .in_window (in_window)
    );

    for (genvar gi = 0; gi < NUM_REGIONS; gi++) begin : g_region
        region_t rg;
        always_comb begin
            rg.en    = reg_en[gi];
            rg.tgt   = reg_tgt[gi*TGT_W +: TGT_W];
            rg.base  = reg_base[gi*PAGE_W +: PAGE_W];
            rg.pages = reg_pages[gi*PAGE_W +: PAGE_W];
        end
        ptd_region_hit u_hit (
            .addr   (addr),
            .region (rg),
            .hole   (holes[gi])
        );
    end

    assign decide = frame_start && mem_en && is_mem && in_window && !(|holes);

    always_ff @(posedge clk) begin
        if (rst) begin
            claim      <= 1'b0;
            sdram_addr <= '0;
        end else begin
            claim      <= decide;
            sdram_addr <= decide ? addr : '0;
        end
    end

    assert_claim_after_start_R8: assert property (@(posedge clk) disable iff (rst)
        claim |-> $past(frame_start));

    assert_claim_needs_enable_R3: assert property (@(posedge clk) disable iff (rst)
        claim |-> $past(mem_en));

    assert_claim_mem_cmd_R2: assert property (@(posedge clk) disable iff (rst)
        claim |-> ($past(cmd) inside {4'b0110, 4'b0111, 4'b1100, 4'b1110, 4'b1111}));

    assert_claim_below_cap_R5: assert property (@(posedge clk) disable iff (rst)
        claim |-> (sdram_addr < LIMIT));

    assert_addr_follows_bus_R9: assert property (@(posedge clk) disable iff (rst)
        claim |-> (sdram_addr == $past(addr)));

    assert_addr_idle_zero_R9: assert property (@(posedge clk) disable iff (rst)
        !claim |-> (sdram_addr == '0));

endmodule

// File: tb/test_pci_tgt_mem_decode.sv
module test_pci_tgt_mem_decode;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        frame_start = 1'b0;
    logic [3:0]  cmd = 4'h0;
    logic [31:0] addr = '0;
    logic        mem_en = 1'b0;
    logic [8:0]  sdram_mb = '0;
    logic [1:0]  reg_en = '0;
    logic [5:0]  reg_tgt = '0;
    logic [39:0] reg_base = '0;
    logic [39:0] reg_pages = '0;
    logic        claim;
    logic [31:0] sdram_addr;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    always #4 clk = ~clk;

    pci_tgt_mem_decode i_pci_tgt_mem_decode (
        .clk(clk), .rst(rst), .frame_start(frame_start), .cmd(cmd), .addr(addr),
        .mem_en(mem_en), .sdram_mb(sdram_mb), .reg_en(reg_en), .reg_tgt(reg_tgt),
        .reg_base(reg_base), .reg_pages(reg_pages), .claim(claim), .sdram_addr(sdram_addr)
    );

    function automatic bit model_claim(input bit fs, input logic [3:0] c, input logic [31:0] a);
        longint unsigned mb, top, lo, hi, av;
        bit mem;
        if (!fs || !mem_en) return 0;
        mem = (c == 4'h6) || (c == 4'h7) || (c == 4'hC) || (c == 4'hE) || (c == 4'hF);
        if (!mem) return 0;
        mb  = (sdram_mb > 256) ? 256 : sdram_mb;
        top = mb * 1048576;
        av  = a;
        if (av >= top) return 0;
        for (int i = 0; i < 2; i++) begin
            lo = longint'(reg_base[i*20 +: 20]) * 4096;
            hi = lo + longint'(reg_pages[i*20 +: 20]) * 4096;
            if (reg_en[i] && reg_tgt[i*3 +: 3] == 3'b001 && av >= lo && av < hi) return 0;
        end
        return 1;
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step(input bit fs, input logic [3:0] c, input logic [31:0] a, input string tag);
        bit e;
        @(negedge clk);
        frame_start = fs; cmd = c; addr = a;
        e = model_claim(fs, c, a);
        @(posedge clk);
        #2;
        check({tag, " claim"}, {31'b0, claim}, {31'b0, e});
        check({tag, " addr R9"}, sdram_addr, e ? a : 32'h0);
    endtask

    task automatic set_region(input int i, input bit en, input logic [2:0] t,
                              input logic [19:0] b, input logic [19:0] p);
        reg_en[i] = en;
        reg_tgt[i*3 +: 3] = t;
        reg_base[i*20 +: 20] = b;
        reg_pages[i*20 +: 20] = p;
    endtask

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        // R1: reset holds outputs low despite a claimable request
        mem_en = 1; sdram_mb = 64;
        repeat (3) begin
            @(negedge clk);
            frame_start = 1; cmd = 4'h6; addr = 32'h100;
            @(posedge clk); #2;
            check("R1 claim in reset", {31'b0, claim}, 32'h0);
            check("R1 addr in reset", sdram_addr, 32'h0);
        end
        @(negedge clk); rst = 0; frame_start = 0;
        @(posedge clk); #2;
        check("R1 claim after release", {31'b0, claim}, 32'h0);

        // R4: window edges
        step(1, 4'h6, 32'h0000_0000, "R4 base");
        step(1, 4'h7, 32'h03FF_FFFF, "R4 last byte");
        step(1, 4'h6, 32'h0400_0000, "R4 past top");
        // R2: every command code
        for (int k = 0; k < 16; k++) step(1, 4'(k), 32'h0000_1000, "R2 cmd sweep");
        // R3
        mem_en = 0;
        step(1, 4'h6, 32'h0000_1000, "R3 disabled");
        step(1, 4'hF, 32'h0000_2000, "R3 disabled wr");
        mem_en = 1;
        // R5
        sdram_mb = 9'd300;
        step(1, 4'h6, 32'h0FFF_FFFF, "R5 cap last");
        step(1, 4'h6, 32'h1000_0000, "R5 cap first out");
        sdram_mb = 9'd256;
        step(1, 4'hC, 32'h1000_0000, "R5 exact cap");
        sdram_mb = 9'd0;
        step(1, 4'h6, 32'h0000_0000, "R4 size zero");
        sdram_mb = 9'd64;
        // R6: region 0 hole A0000..BFFFF
        set_region(0, 1, 3'b001, 20'h000A0, 20'h00020);
        step(1, 4'h6, 32'h0009_FFFF, "R6 below hole");
        step(1, 4'h6, 32'h000A_0000, "R6 hole start");
        step(1, 4'h7, 32'h000B_FFFF, "R6 hole end");
        step(1, 4'h6, 32'h000C_0000, "R6 after hole");
        // R7
        set_region(0, 1, 3'b000, 20'h000A0, 20'h00020);
        step(1, 4'h6, 32'h000A_0000, "R7 target not pci");
        set_region(0, 0, 3'b001, 20'h000A0, 20'h00020);
        step(1, 4'h6, 32'h000A_0000, "R7 disabled region");
        // R6 region 1
        set_region(1, 1, 3'b001, 20'h01000, 20'h00001);
        step(1, 4'h6, 32'h0100_0FFF, "R6 region1 inside");
        step(1, 4'h6, 32'h0100_1000, "R6 region1 after");
        // R10
        set_region(1, 1, 3'b001, 20'h01000, 20'h00000);
        step(1, 4'h6, 32'h0100_0000, "R10 zero size");
        set_region(1, 1, 3'b001, 20'h00800, 20'hFFFFF);
        step(1, 4'h6, 32'h0080_0000, "R10 no wrap start");
        step(1, 4'h6, 32'h007F_FFFF, "R10 no wrap below");
        set_region(1, 0, 3'b000, 20'h0, 20'h0);
        // R8
        step(0, 4'h6, 32'h0000_4000, "R8 no strobe");
        step(1, 4'h6, 32'h0000_4000, "R8 back to back a");
        step(1, 4'h7, 32'h0000_8000, "R8 back to back b");
        step(0, 4'h7, 32'h0000_8000, "R8 pulse ends");

        // random phase, edges emphasised
        for (int n = 0; n < 400; n++) begin
            logic [31:0] a;
            int pick;
            mem_en   = ($urandom % 8) != 0;
            sdram_mb = 9'($urandom % 320);
            for (int i = 0; i < 2; i++)
                set_region(i, 1'($urandom), 3'($urandom % 3), 20'($urandom % 20'h10000),
                           20'($urandom % 20'h400));
            pick = $urandom % 4;
            case (pick)
                0: a = $urandom;
                1: a = (32'(sdram_mb) << 20) - 32'($urandom % 3);
                2: a = {reg_base[19:0], 12'h000} - 32'($urandom % 2);
                default: a = {reg_base[39:20] + reg_pages[39:20], 12'h000} - 32'($urandom % 2);
            endcase
            step(($urandom % 5) != 0, 4'($urandom), a, "R2 R4 R6 random");
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule